// File: doc/BRIEF.md
# Receive Character Queue with Fill Trigger and Idle Time-out

This block buffers the characters a serial receiver delivers. The deserializer pushes each completed byte with a write strobe. The host pulls bytes with a read strobe, and each byte appears on the read-data output one cycle after the strobe. The queue holds up to sixteen bytes.

The block raises a trigger flag once the fill level reaches a host-selected threshold. It also raises a time-out flag when bytes have sat in the queue for four character times with no new stop bit and no host read. The time-out lets bytes below the threshold still reach the host. The time-out window follows the programmed character format.

When the queue-enable control is low, the storage behaves as a single holding register.

Top module: `rxq_buffer`

## Requirements
- R1: Bytes are read back in the order they were written. A read strobe on a non-empty queue loads the oldest byte onto `rd_data` at the next clock edge. With the queue enabled, `full` is 1 at exactly 16 stored bytes.
- R2: With the queue enabled, `trig` is 1 when `level` is at or above the threshold picked by `trig_sel`: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. Otherwise `trig` is 0.
- R3: A write while `full` is 1 and no read is in the same cycle discards the byte and sets `overrun`. `overrun` stays 1 until reset.
- R4: A read strobe while the queue is empty leaves `rd_data` and `level` unchanged.
- R5: `tick` pulses at twice the bit rate. The data length is 5 + `len_sel` bits. `par_en` adds one parity bit. The stop length is set by `stop_sel`: 00 is one bit, 01 is one and a half bits, and 10 or 11 is two bits. With the queue non-empty, `tmo` rises on the Nth tick, where N = 4 × (2 × (1 + data bits + parity) + stop half-bits).
- R6: A `stop_mid` pulse restarts the time-out count from zero. A tick in the same cycle as the pulse is not counted.
- R7: A read of a non-empty queue clears `tmo` at the next edge and restarts the count. `tmo` sets again only after another full window while bytes remain.
- R8: `tmo` is never 1 while `empty` is 1.
- R9: With `fifo_en` low, the storage holds one byte and the threshold is 1. A second write before a read sets `overrun`.
- R10: A change of `fifo_en` empties the queue at the next edge.
- R11: After reset, `empty` is 1, `level` is 0, `rd_data` is 0, and `trig`, `tmo`, `full` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte-write strobe from the deserializer |
| wr_data | input | 8 | Received byte |
| stop_mid | input | 1 | Pulse at the center of each received stop bit |
| rd_en | input | 1 | Host read strobe |
| tick | input | 1 | Pulse at twice the bit rate |
| len_sel | input | 2 | Data length code, 5 + value bits |
| par_en | input | 1 | Parity bit present |
| stop_sel | input | 2 | Stop length code |
| fifo_en | input | 1 | Queue enable; low gives a one-byte holding register |
| trig_sel | input | 2 | Threshold select |
| rd_data | output | 8 | Byte from the last accepted read |
| data_rdy | output | 1 | At least one byte stored |
| trig | output | 1 | Fill level at or above the threshold |
| tmo | output | 1 | Character time-out |
| level | output | 5 | Number of stored bytes |
| empty | output | 1 | No byte stored |
| full | output | 1 | Storage at capacity |
| overrun | output | 1 | Sticky lost-byte flag |

## Verification
Each threshold code is driven with fill levels one below and exactly at its threshold, plus a completely full queue. These patterns show the comparison boundary and confirm the code-to-threshold mapping.

The time-out is measured in two frame formats, checking one tick before and exactly at the computed window. This distinguishes the stop and parity arithmetic from a counter that is off by one.

Two further patterns test the count's restart logic. A stop-bit pulse part way through the window must push the flag out by a full window. A read with bytes still stored must re-arm the flag.

Fill-to-capacity with an extra write, reads on an empty queue, the one-byte mode and the enable-change flush cover ordering, loss and retained state.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef enum logic [1:0] {
      STOP_ONE      = 2'b00,
      STOP_ONE_HALF = 2'b01,
      STOP_TWO      = 2'b10,
      STOP_TWO_ALT  = 2'b11
   } stop_code_e;

   // threshold in characters for a select code
   function automatic int unsigned thr_of(input logic [1:0] sel);
      case (sel)
         2'b00:   thr_of = 1;
         2'b01:   thr_of = 4;
         2'b10:   thr_of = 8;
         default: thr_of = 14;
      endcase
   endfunction

   // one character time in half-bit units
   function automatic int unsigned half_units(input logic [1:0] len_sel,
                                              input logic       par_en,
                                              input logic [1:0] stop_sel);
      int unsigned bits;
      int unsigned stop_h;
      bits = 1 + 5 + int'(len_sel) + (par_en ? 1 : 0);
      case (stop_code_e'(stop_sel))
         STOP_ONE:      stop_h = 2;
         STOP_ONE_HALF: stop_h = 3;
         default:       stop_h = 4;
      endcase
      half_units = 2 * bits + stop_h;
   endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          cap_one,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          rd,
   output logic          rd_ok,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full,
   output logic          ovr
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cap;
   logic          wr_ok;

   assign cap   = cap_one ? CW'(1) : CW'(DEPTH);
   assign empty = (count == '0);
   assign full  = (count == cap);
   assign rd_ok = rd && !empty;
   assign wr_ok = wr && (!full || rd_ok);

   always_ff @(posedge clk) begin
      if (wr_ok && !flush) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
         rdata <= '0;
         ovr   <= 1'b0;
      end else begin
         if (wr && !wr_ok) ovr <= 1'b1;
         if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
         end else begin
            if (wr_ok) wptr <= wptr + 1'b1;
            if (rd_ok) begin
               rdata <= mem[rptr];
               rptr  <= rptr + 1'b1;
            end
            case ({wr_ok, rd_ok})
               2'b10:   count <= count + 1'b1;
               2'b01:   count <= count - 1'b1;
               default: count <= count;
            endcase
         end
      end
   end
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic [CW-1:0] count,
   input  logic [1:0]    sel,
   input  logic          fifo_en,
   output logic          hit
);
   import rxq_pkg::*;
   int unsigned thr;

   always_comb begin
      thr = fifo_en ? thr_of(sel) : 1;
      hit = (int'(count) >= int'(thr));
   end
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
   parameter int MAX_DATA = 8,
   localparam int MAX_LIM = 4 * (2 * (2 + MAX_DATA) + 4),
   localparam int TW      = $clog2(MAX_LIM + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       stop_mid,
   input  logic       rd_ok,
   input  logic       flush,
   input  logic       empty,
   input  logic [1:0] len_sel,
   input  logic       par_en,
   input  logic [1:0] stop_sel,
   output logic       tmo
);
   import rxq_pkg::*;
   logic [TW-1:0] cnt;
   logic [TW-1:0] limit;

   always_comb limit = TW'(4 * half_units(len_sel, par_en, stop_sel));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         tmo <= 1'b0;
      end else if (flush || rd_ok) begin
         cnt <= '0;
         tmo <= 1'b0;
      end else if (stop_mid || empty) begin
         cnt <= '0;
      end else if (tick && !tmo) begin
         if (cnt == (limit - TW'(1))) begin
            cnt <= '0;
            tmo <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer #(
   parameter int DEPTH    = 16,
   parameter int DW       = 8,
   parameter int MAX_DATA = 8,
   localparam int CW      = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          stop_mid,
   input  logic          rd_en,
   input  logic          tick,
   input  logic [1:0]    len_sel,
   input  logic          par_en,
   input  logic [1:0]    stop_sel,
   input  logic          fifo_en,
   input  logic [1:0]    trig_sel,
   output logic [DW-1:0] rd_data,
   output logic          data_rdy,
   output logic          trig,
   output logic          tmo,
   output logic [CW-1:0] level,
   output logic          empty,
   output logic          full,
   output logic          overrun
);
   generate
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
         $error("rxq_buffer: DEPTH must be a power of two");
      end
      if (DEPTH < 14) begin : g_bad_depth
         $error("rxq_buffer: DEPTH must cover the largest threshold");
      end
      if (DW < MAX_DATA) begin : g_bad_width
         $error("rxq_buffer: DW narrower than MAX_DATA");
      end
   endgenerate

   logic en_q;
   logic flush;
   logic rd_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= fifo_en;
   end
   assign flush = (fifo_en != en_q);

   rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush), .cap_one(!fifo_en),
      .wr(wr_en), .wdata(wr_data), .rd(rd_en), .rd_ok(rd_ok),
      .rdata(rd_data), .count(level), .empty(empty), .full(full),
      .ovr(overrun)
   );

   rxq_level #(.DEPTH(DEPTH)) u_level (
      .count(level), .sel(trig_sel), .fifo_en(fifo_en), .hit(trig)
   );

   rxq_timer #(.MAX_DATA(MAX_DATA)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .stop_mid(stop_mid),
      .rd_ok(rd_ok), .flush(flush), .empty(empty), .len_sel(len_sel),
      .par_en(par_en), .stop_sel(stop_sel), .tmo(tmo)
   );

   assign data_rdy = !empty;
endmodule

// File: rtl/rxq_buffer_chk.sv
module rxq_buffer_chk #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          rd_en,
   input logic          fifo_en,
   input logic [1:0]    trig_sel,
   input logic [DW-1:0] rd_data,
   input logic [CW-1:0] level,
   input logic          empty,
   input logic          full,
   input logic          overrun,
   input logic          tmo,
   input logic          trig
);
   // R1: never more than DEPTH bytes held
   p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) <= DEPTH);

   // R2: the top threshold is not met below 14 bytes
   p_trig_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && trig_sel == 2'b11 && int'(level) < 14) |-> !trig);

   // R3: a write into a full store with no read raises overrun
   p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !rd_en) |=> overrun);

   // R3: overrun is sticky
   p_overrun_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R4: an empty read disturbs nothing
   p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && empty && !wr_en) |=> ($stable(rd_data) && level == '0));

   // R7: an accepted read drops the time-out
   p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !empty) |=> !tmo);

   // R8: no time-out while empty
   p_tmo_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |-> !empty);

   // R9: disabled mode holds at most one byte once settled
   p_one_deep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && $past(!fifo_en)) |-> int'(level) <= 1);
endmodule

bind rxq_buffer rxq_buffer_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
   .fifo_en(fifo_en), .trig_sel(trig_sel), .rd_data(rd_data),
   .level(level), .empty(empty), .full(full), .overrun(overrun),
   .tmo(tmo), .trig(trig)
);

// File: tb/rxq_buffer_tb.sv
`timescale 1ns/1ps
module rxq_buffer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 0, stop_mid = 0, rd_en = 0, tick = 0;
   logic [7:0] wr_data = '0;
   logic [1:0] len_sel = 2'b11, stop_sel = 2'b00, trig_sel = 2'b00;
   logic       par_en = 0, fifo_en = 1;
   logic [7:0] rd_data;
   logic       data_rdy, trig, tmo, empty, full, overrun;
   logic [4:0] level;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   rxq_buffer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .stop_mid(stop_mid), .rd_en(rd_en), .tick(tick), .len_sel(len_sel),
      .par_en(par_en), .stop_sel(stop_sel), .fifo_en(fifo_en),
      .trig_sel(trig_sel), .rd_data(rd_data), .data_rdy(data_rdy),
      .trig(trig), .tmo(tmo), .level(level), .empty(empty), .full(full),
      .overrun(overrun)
   );

   // {trig_sel[1:0], writes[4:0], expected trig}
   localparam logic [7:0] VEC [9] = '{
      {2'b00, 5'd0,  1'b0}, {2'b00, 5'd1,  1'b1},
      {2'b01, 5'd3,  1'b0}, {2'b01, 5'd4,  1'b1},
      {2'b10, 5'd7,  1'b0}, {2'b10, 5'd8,  1'b1},
      {2'b11, 5'd13, 1'b0}, {2'b11, 5'd14, 1'b1},
      {2'b11, 5'd16, 1'b1}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic put(input logic [7:0] b);
      wr_en = 1'b1; wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pull();
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic run_ticks(input int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic window(input string tag, input int n);
      run_ticks(n - 1);
      chk({tag, " tmo one tick early"}, int'(tmo), 0);
      run_ticks(1);
      chk({tag, " tmo at window"}, int'(tmo), 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R11 reset state
      chk("R11 empty", int'(empty), 1);
      chk("R11 level", int'(level), 0);
      chk("R11 rd_data", int'(rd_data), 0);
      chk("R11 flags", int'({trig, tmo, full, overrun}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 threshold table
      for (int i = 0; i < 9; i++) begin
         do_reset();
         trig_sel = VEC[i][7:6];
         for (int k = 0; k < int'(VEC[i][5:1]); k++) put(8'(k));
         chk($sformatf("R2 trig vec %0d", i), int'(trig), int'(VEC[i][0]));
         chk($sformatf("R2 level vec %0d", i), int'(level), int'(VEC[i][5:1]));
      end

      // R1 order and capacity, R3 overrun
      do_reset();
      for (int k = 0; k < 16; k++) put(8'h10 + 8'(k));
      chk("R1 full at 16", int'(full), 1);
      chk("R3 no overrun yet", int'(overrun), 0);
      put(8'hEE);
      chk("R3 overrun set", int'(overrun), 1);
      chk("R3 level held", int'(level), 16);
      for (int k = 0; k < 16; k++) begin
         pull();
         chk($sformatf("R1 order byte %0d", k), int'(rd_data), 16 + k);
      end
      chk("R1 empty after drain", int'(empty), 1);
      chk("R3 overrun sticky", int'(overrun), 1);

      // R4 empty read
      pull();
      chk("R4 rd_data kept", int'(rd_data), 8'h1F);
      chk("R4 level kept", int'(level), 0);

      // R5 window, 8 data, no parity, 1 stop: 80 ticks
      do_reset();
      len_sel = 2'b11; par_en = 0; stop_sel = 2'b00;
      put(8'h5A);
      window("R5 8N1", 80);
      // R7 read clears, R8 none while empty
      pull();
      chk("R7 tmo cleared", int'(tmo), 0);
      chk("R7 byte", int'(rd_data), 8'h5A);
      run_ticks(200);
      chk("R8 no tmo when empty", int'(tmo), 0);

      // R6 stop-bit restart
      put(8'h61);
      run_ticks(50);
      tick = 1'b1; stop_mid = 1'b1;
      @(negedge clk);
      stop_mid = 1'b0; tick = 1'b0;
      window("R6 restart", 80);

      // R7 re-arm with a byte remaining
      put(8'h62);
      pull();
      chk("R7 cleared with data left", int'(tmo), 0);
      window("R7 rearm", 80);

      // R5 window, 5 data, parity, 1.5 stop: 68 ticks
      do_reset();
      len_sel = 2'b00; par_en = 1; stop_sel = 2'b01;
      put(8'h07);
      window("R5 5P1.5", 68);
      // R5 two stop bits, 7 data, no parity: 4*(2*8+4) = 80
      do_reset();
      len_sel = 2'b10; par_en = 0; stop_sel = 2'b10;
      put(8'h08);
      window("R5 7N2", 80);

      // R9 one-deep mode
      do_reset();
      fifo_en = 1'b0; trig_sel = 2'b11;
      @(negedge clk);
      put(8'h33);
      chk("R9 level one", int'(level), 1);
      chk("R9 full at one", int'(full), 1);
      chk("R9 trigger one", int'(trig), 1);
      put(8'h44);
      chk("R9 overrun", int'(overrun), 1);
      pull();
      chk("R9 first byte kept", int'(rd_data), 8'h33);
      chk("R9 empty", int'(empty), 1);

      // R10 flush on enable change
      do_reset();
      fifo_en = 1'b1;
      @(negedge clk);
      put(8'h01); put(8'h02); put(8'h03);
      chk("R10 level before", int'(level), 3);
      fifo_en = 1'b0;
      @(negedge clk);
      chk("R10 flushed", int'(level), 0);
      chk("R10 empty", int'(empty), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule